// File: doc/BRIEF.md
# Flattened Nested Transaction Controller

This block sequences hardware transactions for a single thread. Nested transactions are flattened into one: only the outermost begin starts a transaction and records its fallback target. Each later begin only raises a nesting depth counter, and each inner end lowers it. When the outermost end arrives, the block issues a commit request and waits for the memory side to report whether the commit succeeded.

Any abort unwinds the whole nest in one step. Abort sources are an explicit abort command, an external conflict or capacity event, a begin past the depth limit, or a failed commit. On abort the block pulses rollback and redirect, presents the outermost fallback target, and publishes an 8-bit cause byte for the result register. The checkpoint storage for registers and memory lives outside the block. This block only raises the pulses that drive it.

Top module: `txn_nest_ctrl`

## Requirements
- R1: After reset the block is idle: `in_txn_o`=0, `depth_o`=0, all pulses low, `abort_status_o`=0 and `end_idle_err_o`=0.
- R2: A begin while idle sets `in_txn_o`, sets depth to 1 and latches the begin target, which then appears on `redirect_addr_o`. All outputs are registered, so the change is visible one cycle after the input.
- R3: A begin while active and below the limit raises depth by one and leaves `redirect_addr_o` unchanged.
- R4: An end at depth above 1 lowers depth by one and raises no commit request.
- R5: An end at depth 1 gives a one-cycle `commit_req_o` pulse. `in_txn_o` and depth stay at 1 until a commit response arrives. A successful response returns the block to idle with no rollback.
- R6: A begin at depth MAX_DEPTH (7 by default) aborts, and the status has bit3 (nest overflow) set.
- R7: Every abort pulses `rollback_o` and `redirect_o` together for one cycle. Depth drops to 0, `in_txn_o` drops, and `redirect_addr_o` shows the outermost begin's target.
- R8: The status byte is laid out as follows, and it is held until the next abort:
  - bit0: explicit abort
  - bit1: conflict
  - bit2: capacity
  - bit3: nest overflow
  - bits[7:4]: the low nibble of the explicit immediate, or 0 for any abort that is not explicit
- R9: An explicit abort while active aborts in the next cycle, like a failed commit. While idle it has no effect.
- R10: A failed commit response aborts with status 0x02.
- R11: External conflict or capacity requests abort while active or while waiting for a commit. Their bits are ORed into the status. While idle they are ignored.
- R12: An end while idle changes no state and raises `end_idle_err_o`, which stays high until reset.
- R13: When several commands arrive in one cycle, explicit abort wins over begin, and begin wins over end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| begin_i | input | 1 | Begin command |
| begin_target_i | input | AW | Fallback target carried with the begin |
| end_i | input | 1 | End command |
| xabort_i | input | 1 | Explicit abort command |
| xabort_imm_i | input | 8 | Explicit abort immediate |
| ext_conflict_i | input | 1 | External conflict abort request |
| ext_capacity_i | input | 1 | External capacity abort request |
| commit_resp_valid_i | input | 1 | Commit result valid |
| commit_resp_ok_i | input | 1 | Commit succeeded when high |
| in_txn_o | output | 1 | Transaction active |
| depth_o | output | DW | Current nesting depth |
| commit_req_o | output | 1 | Commit request pulse |
| rollback_o | output | 1 | Rollback pulse |
| redirect_o | output | 1 | Redirect pulse |
| redirect_addr_o | output | AW | Outermost fallback target |
| abort_status_o | output | 8 | Abort cause byte |
| end_idle_err_o | output | 1 | Sticky error: end while idle |

## Verification
The bench builds nests of every depth from 1 to 7 and aborts each one with every abort source, computing the expected cause byte arithmetically. A design that kept the innermost target, or that unwound only one level, shows a wrong `redirect_addr_o` or a nonzero depth after rollback. The bench drives the eighth begin to hit the depth limit; a design whose counter wraps would report depth 0 while still in a transaction and give no overflow status. Commits that succeed, that fail, and that are cut off by an external abort are all checked, as are combined commands in one cycle. These catch an inverted response sense, a commit fired at an inner end, and a wrong command priority.

// File: rtl/txn_pkg.sv
package txn_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_COMMIT = 2'd2
    } txn_state_e;

    typedef enum logic [1:0] {
        DOP_HOLD = 2'd0,
        DOP_INC  = 2'd1,
        DOP_DEC  = 2'd2,
        DOP_CLR  = 2'd3
    } depth_op_e;

    localparam int STATUS_W    = 8;
    localparam int CB_EXPLICIT = 0;
    localparam int CB_CONFLICT = 1;
    localparam int CB_CAPACITY = 2;
    localparam int CB_OVERFLOW = 3;
    localparam int IMM_LSB     = 4;
    localparam int IMM_KEEP_W  = STATUS_W - IMM_LSB;

    typedef struct packed {
        txn_state_e          state;
        logic                commit_req;
        logic                rollback;
        logic [STATUS_W-1:0] status;
        logic                err;
    } txn_ctl_t;

endpackage

// File: rtl/txn_depth_track.sv
module txn_depth_track
    import txn_pkg::*;
#(
    parameter int MAX_DEPTH = 7,
    localparam int DW = $clog2(MAX_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  depth_op_e     op_i,
    output logic [DW-1:0] depth_o,
    output logic          at_max_o,
    output logic          at_one_o
);

    localparam logic [DW-1:0] DEPTH_MAX = DW'(MAX_DEPTH);
    localparam logic [DW-1:0] DEPTH_ONE = DW'(1);

    logic [DW-1:0] depth_d, depth_q;

    always_comb begin
        depth_d = depth_q;
        unique case (op_i)
            DOP_INC:  depth_d = (depth_q == DEPTH_MAX) ? depth_q : depth_q + DEPTH_ONE;
            DOP_DEC:  depth_d = (depth_q == '0) ? depth_q : depth_q - DEPTH_ONE;
            DOP_CLR:  depth_d = '0;
            default:  depth_d = depth_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) depth_q <= '0;
        else        depth_q <= depth_d;
    end

    assign depth_o  = depth_q;
    assign at_max_o = (depth_q == DEPTH_MAX);
    assign at_one_o = (depth_q == DEPTH_ONE);

    AST_DEPTH_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q <= DEPTH_MAX); // R6

    AST_NO_INC_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == DOP_INC) |-> (depth_q != DEPTH_MAX)); // R6

    AST_NO_DEC_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == DOP_DEC) |-> (depth_q > DEPTH_ONE)); // R4

endmodule

// File: rtl/txn_fallback_hold.sv
module txn_fallback_hold #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_i,
    input  logic [AW-1:0] target_i,
    input  logic          in_txn_i,
    output logic [AW-1:0] target_o
);

    logic [AW-1:0] tgt_d, tgt_q;

    always_comb begin
        tgt_d = tgt_q;
        if (capture_i) tgt_d = target_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tgt_q <= '0;
        else        tgt_q <= tgt_d;
    end

    assign target_o = tgt_q;

    AST_FALLBACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_txn_i && $past(in_txn_i)) |-> $stable(tgt_q)); // R3

    AST_CAPTURE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |-> !in_txn_i); // R2

endmodule

// File: rtl/txn_cause_enc.sv
module txn_cause_enc
    import txn_pkg::*;
(
    input  logic                  explicit_i,
    input  logic [IMM_KEEP_W-1:0] imm_nib_i,
    input  logic                  conflict_i,
    input  logic                  capacity_i,
    input  logic                  overflow_i,
    output logic [STATUS_W-1:0]   status_o
);

    always_comb begin
        status_o = '0;
        status_o[CB_EXPLICIT] = explicit_i;
        status_o[CB_CONFLICT] = conflict_i;
        status_o[CB_CAPACITY] = capacity_i;
        status_o[CB_OVERFLOW] = overflow_i;
        for (int i = 0; i < IMM_KEEP_W; i++) begin
            status_o[IMM_LSB + i] = explicit_i & imm_nib_i[i];
        end
    end

    always_comb begin
        assert (explicit_i || (status_o[STATUS_W-1:IMM_LSB] == '0)); // R8
    end

endmodule

// File: rtl/txn_nest_ctrl.sv
module txn_nest_ctrl
    import txn_pkg::*;
#(
    parameter int AW        = 16,
    parameter int MAX_DEPTH = 7,
    localparam int DW = $clog2(MAX_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                begin_i,
    input  logic [AW-1:0]       begin_target_i,
    input  logic                end_i,
    input  logic                xabort_i,
    input  logic [STATUS_W-1:0] xabort_imm_i,
    input  logic                ext_conflict_i,
    input  logic                ext_capacity_i,
    input  logic                commit_resp_valid_i,
    input  logic                commit_resp_ok_i,
    output logic                in_txn_o,
    output logic [DW-1:0]       depth_o,
    output logic                commit_req_o,
    output logic                rollback_o,
    output logic                redirect_o,
    output logic [AW-1:0]       redirect_addr_o,
    output logic [STATUS_W-1:0] abort_status_o,
    output logic                end_idle_err_o
);

    txn_ctl_t ctl_d, ctl_q;
    depth_op_e dop;
    logic capture;
    logic at_max, at_one;

    // command priority: explicit abort, then begin, then end
    logic cmd_x, cmd_b, cmd_e, ext_any;
    logic st_idle, st_active, st_commit;
    logic ab_explicit, ab_conflict, ab_capacity, ab_overflow, do_abort;
    logic [STATUS_W-1:0] cause_byte;

    assign cmd_x   = xabort_i;
    assign cmd_b   = begin_i & ~xabort_i;
    assign cmd_e   = end_i & ~xabort_i & ~begin_i;
    assign ext_any = ext_conflict_i | ext_capacity_i;

    assign st_idle   = (ctl_q.state == ST_IDLE);
    assign st_active = (ctl_q.state == ST_ACTIVE);
    assign st_commit = (ctl_q.state == ST_COMMIT);

    assign ab_explicit = st_active & cmd_x;
    assign ab_overflow = st_active & cmd_b & at_max;
    assign ab_capacity = ~st_idle & ext_capacity_i;
    assign ab_conflict = (~st_idle & ext_conflict_i)
                       | (st_commit & ~ext_any & commit_resp_valid_i & ~commit_resp_ok_i);
    assign do_abort    = ab_explicit | ab_overflow | ab_capacity | ab_conflict;

    txn_cause_enc u_cause (
        .explicit_i (ab_explicit),
        .imm_nib_i  (xabort_imm_i[IMM_KEEP_W-1:0]),
        .conflict_i (ab_conflict),
        .capacity_i (ab_capacity),
        .overflow_i (ab_overflow),
        .status_o   (cause_byte)
    );

    txn_depth_track #(.MAX_DEPTH(MAX_DEPTH)) u_depth (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (dop),
        .depth_o  (depth_o),
        .at_max_o (at_max),
        .at_one_o (at_one)
    );

    txn_fallback_hold #(.AW(AW)) u_fallback (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .target_i  (begin_target_i),
        .in_txn_i  (in_txn_o),
        .target_o  (redirect_addr_o)
    );

    always_comb begin
        ctl_d            = ctl_q;
        ctl_d.commit_req = 1'b0;
        ctl_d.rollback   = 1'b0;
        dop              = DOP_HOLD;
        capture          = 1'b0;

        if (do_abort) begin
            ctl_d.state    = ST_IDLE;
            ctl_d.rollback = 1'b1;
            ctl_d.status   = cause_byte;
            dop            = DOP_CLR;
        end else begin
            unique case (ctl_q.state)
                ST_IDLE: begin
                    if (cmd_b) begin
                        ctl_d.state = ST_ACTIVE;
                        dop         = DOP_INC;
                        capture     = 1'b1;
                    end else if (cmd_e) begin
                        ctl_d.err = 1'b1;
                    end
                end
                ST_ACTIVE: begin
                    if (cmd_b) begin
                        dop = DOP_INC;
                    end else if (cmd_e) begin
                        if (at_one) begin
                            ctl_d.state      = ST_COMMIT;
                            ctl_d.commit_req = 1'b1;
                        end else begin
                            dop = DOP_DEC;
                        end
                    end
                end
                ST_COMMIT: begin
                    if (commit_resp_valid_i && commit_resp_ok_i) begin
                        ctl_d.state = ST_IDLE;
                        dop         = DOP_CLR;
                    end
                end
                default: begin
                    ctl_d.state = ST_IDLE;
                    dop         = DOP_CLR;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.state      <= ST_IDLE;
            ctl_q.commit_req <= 1'b0;
            ctl_q.rollback   <= 1'b0;
            ctl_q.status     <= '0;
            ctl_q.err        <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign in_txn_o       = ~st_idle;
    assign commit_req_o   = ctl_q.commit_req;
    assign rollback_o     = ctl_q.rollback;
    assign redirect_o     = ctl_q.rollback;
    assign abort_status_o = ctl_q.status;
    assign end_idle_err_o = ctl_q.err;

    AST_IDLE_DEPTH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !in_txn_o |-> (depth_o == '0)); // R7

    AST_ACTIVE_DEPTH_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        in_txn_o |-> (depth_o != '0)); // R2

    AST_COMMIT_AT_OUTER: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req_o |-> (in_txn_o && depth_o == DW'(1))); // R5

    AST_ROLLBACK_UNWINDS: assert property (@(posedge clk) disable iff (!rst_n)
        rollback_o |-> (!in_txn_o && depth_o == '0)); // R7

    AST_ROLLBACK_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rollback_o |-> (abort_status_o[CB_OVERFLOW:CB_EXPLICIT] != '0)); // R8

    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rollback_o |-> $stable(abort_status_o)); // R8

    AST_IMM_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rollback_o && abort_status_o[CB_EXPLICIT])
        |-> ({4'h0, abort_status_o[STATUS_W-1:IMM_LSB]} == ($past(xabort_imm_i) & 8'h0F))); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(end_idle_err_o) |-> end_idle_err_o); // R12

    AST_NO_COMMIT_WITH_ROLLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_req_o && rollback_o)); // R5

endmodule

// File: tb/tb_txn_nest_ctrl.sv
`timescale 1ns/1ps
module tb_txn_nest_ctrl;

    localparam int AW = 16;
    localparam int MAXD = 7;
    localparam int DW = $clog2(MAXD + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic begin_i = 0, end_i = 0, xabort_i = 0;
    logic [AW-1:0] begin_target_i = '0;
    logic [7:0] xabort_imm_i = '0;
    logic ext_conflict_i = 0, ext_capacity_i = 0;
    logic commit_resp_valid_i = 0, commit_resp_ok_i = 0;
    logic in_txn_o, commit_req_o, rollback_o, redirect_o, end_idle_err_o;
    logic [DW-1:0] depth_o;
    logic [AW-1:0] redirect_addr_o;
    logic [7:0] abort_status_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    txn_nest_ctrl #(.AW(AW), .MAX_DEPTH(MAXD)) dut (
        .clk(clk), .rst_n(rst_n),
        .begin_i(begin_i), .begin_target_i(begin_target_i),
        .end_i(end_i), .xabort_i(xabort_i), .xabort_imm_i(xabort_imm_i),
        .ext_conflict_i(ext_conflict_i), .ext_capacity_i(ext_capacity_i),
        .commit_resp_valid_i(commit_resp_valid_i), .commit_resp_ok_i(commit_resp_ok_i),
        .in_txn_o(in_txn_o), .depth_o(depth_o), .commit_req_o(commit_req_o),
        .rollback_o(rollback_o), .redirect_o(redirect_o),
        .redirect_addr_o(redirect_addr_o), .abort_status_o(abort_status_o),
        .end_idle_err_o(end_idle_err_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000 && !done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<50000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // drive inputs at a negedge, let one posedge pass, sample at the next negedge
    task automatic drive(input logic b, input logic [AW-1:0] a, input logic e,
                         input logic x, input logic [7:0] imm, input logic c,
                         input logic p, input logic rv, input logic rok);
        begin_i = b; begin_target_i = a; end_i = e; xabort_i = x; xabort_imm_i = imm;
        ext_conflict_i = c; ext_capacity_i = p;
        commit_resp_valid_i = rv; commit_resp_ok_i = rok;
        @(negedge clk);
        begin_i = 0; end_i = 0; xabort_i = 0; ext_conflict_i = 0; ext_capacity_i = 0;
        commit_resp_valid_i = 0; commit_resp_ok_i = 0;
    endtask

    task automatic do_idle();              drive(0, '0, 0, 0, 8'h00, 0, 0, 0, 0); endtask
    task automatic do_begin(input logic [AW-1:0] a); drive(1, a, 0, 0, 8'h00, 0, 0, 0, 0); endtask
    task automatic do_end();               drive(0, '0, 1, 0, 8'h00, 0, 0, 0, 0); endtask
    task automatic do_xabort(input logic [7:0] imm); drive(0, '0, 0, 1, imm, 0, 0, 0, 0); endtask
    task automatic do_ext(input logic c, input logic p); drive(0, '0, 0, 0, 8'h00, c, p, 0, 0); endtask
    task automatic do_resp(input logic ok); drive(0, '0, 0, 0, 8'h00, 0, 0, 1, ok); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 in_txn", in_txn_o, 0);
        chk("R1 depth", depth_o, 0);
        chk("R1 pulses", {commit_req_o, rollback_o, redirect_o}, 0);
        chk("R1 status", abort_status_o, 0);
        chk("R1 err", end_idle_err_o, 0);

        // R12 end while idle
        do_end();
        chk("R12 idle end no txn", in_txn_o, 0);
        chk("R12 idle end depth", depth_o, 0);
        chk("R12 err raised", end_idle_err_o, 1);
        // R9 explicit abort while idle ignored
        do_xabort(8'hFF);
        chk("R9 idle xabort no rollback", {rollback_o, in_txn_o}, 0);
        chk("R9 idle xabort status", abort_status_o, 0);
        // R11 external while idle ignored
        do_ext(1, 1);
        chk("R11 idle ext no rollback", rollback_o, 0);
        chk("R11 idle ext status", abort_status_o, 0);

        // R2 R3 nest up to the limit, then R6 overflow
        for (int d = 1; d <= MAXD; d++) begin
            do_begin(16'h1000 + 16'(d));
            chk($sformatf("R3 depth after begin %0d", d), depth_o, d);
            chk($sformatf("R2 target held at %0d", d), redirect_addr_o, 16'h1001);
            chk("R2 in_txn", in_txn_o, 1);
        end
        do_begin(16'h2222);
        chk("R6 overflow rollback", {rollback_o, redirect_o}, 3);
        chk("R6 overflow status", abort_status_o, 8'h08);
        chk("R7 overflow depth", depth_o, 0);
        chk("R7 overflow idle", in_txn_o, 0);
        chk("R7 overflow target", redirect_addr_o, 16'h1001);
        do_idle();
        chk("R7 pulse one cycle", {rollback_o, redirect_o}, 0);
        chk("R8 status held", abort_status_o, 8'h08);

        // R7 R8 R9 R11 sweep: every depth, every abort source
        for (int d = 1; d <= MAXD; d++) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] imm;
                int exp;
                imm = 8'(d * 37 + k * 11);
                for (int j = 1; j <= d; j++) do_begin(16'(16'h0100 * d + j));
                chk("R3 sweep depth", depth_o, d);
                case (k)
                    0: begin do_xabort(imm); exp = {imm[3:0], 4'b0001}; end
                    1: begin do_ext(1, 0); exp = 8'h02; end
                    2: begin do_ext(0, 1); exp = 8'h04; end
                    default: begin do_ext(1, 1); exp = 8'h06; end
                endcase
                chk($sformatf("R8 status d%0d k%0d", d, k), abort_status_o, exp);
                chk($sformatf("R7 unwind d%0d k%0d", d, k),
                    {rollback_o, redirect_o, in_txn_o, 4'(depth_o)}, 7'b1100000);
                chk($sformatf("R7 outer target d%0d k%0d", d, k), redirect_addr_o,
                    16'h0100 * d + 1);
                do_idle();
            end
        end

        // R4 R5 R10 commit paths
        for (int d = 1; d <= MAXD; d++) begin
            int prev;
            for (int j = 1; j <= d; j++) do_begin(16'h3000 + 16'(j));
            for (int j = d; j > 1; j--) begin
                do_end();
                chk("R4 inner end depth", depth_o, j - 1);
                chk("R4 inner end no commit", commit_req_o, 0);
            end
            prev = abort_status_o;
            do_end();
            chk("R5 commit pulse", commit_req_o, 1);
            chk("R5 waiting in_txn", {in_txn_o, 4'(depth_o)}, 5'b10001);
            do_idle();
            chk("R5 pulse one cycle", commit_req_o, 0);
            chk("R5 still waiting", in_txn_o, 1);
            if (d % 2 == 1) begin
                do_resp(1);
                chk("R5 commit ok idle", {in_txn_o, 4'(depth_o), rollback_o}, 0);
                chk("R8 status kept after commit", abort_status_o, prev);
            end else begin
                do_resp(0);
                chk("R10 failed commit rollback", {rollback_o, redirect_o, in_txn_o}, 3'b110);
                chk("R10 failed commit status", abort_status_o, 8'h02);
            end
            do_idle();
        end

        // R11 external abort while waiting for commit
        do_begin(16'h4444);
        do_end();
        do_ext(0, 1);
        chk("R11 ext during commit", {rollback_o, in_txn_o}, 2'b10);
        chk("R11 ext during commit status", abort_status_o, 8'h04);
        chk("R11 ext during commit target", redirect_addr_o, 16'h4444);

        // R13 priority
        do_begin(16'h5555);
        do_begin(16'h6666);
        drive(1, 16'h7777, 1, 0, 8'h00, 0, 0, 0, 0);
        chk("R13 begin beats end", depth_o, 3);
        drive(1, 16'h7777, 1, 1, 8'h5A, 0, 0, 0, 0);
        chk("R13 xabort wins", abort_status_o, 8'hA1);
        chk("R13 xabort target", redirect_addr_o, 16'h5555);
        chk("R13 xabort unwind", {in_txn_o, 4'(depth_o)}, 0);

        chk("R12 err sticky", end_idle_err_o, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule